// File: doc/BRIEF.md
# Watchdog Timer with Selectable Timeout Response

This block is a bus-mapped watchdog. Software loads a timeout limit, counted in timer ticks, and then turns the timer on. Every `TICK_DIV` clock cycles it advances a 32-bit up-counter while it is enabled. Software keeps the system alive by writing zero to the count register before the counter reaches the limit. If the counter reaches the limit, the block records the event in two sticky flags, one in the control register and one in the response register. In the same cycle it emits a one-cycle request on the non-maskable interrupt output, the warm-reset output, both, or neither. Two independent enable bits choose which.

After a timeout the counter parks at the limit. Only a write to the count register releases it, so a missed keep-alive produces exactly one event and the counter never wraps. With the default tick of half the clock rate, a full 32-bit limit at a 400 MHz clock is roughly 21 seconds.

Top module: `wdog_timer`

## Requirements
- R1: After reset, all four registers read zero and both request outputs are low.
- R2: Registers are selected by word address: 0 is control (bit 0 run enable, bit 1 expired flag), 1 is count, 2 is limit, 3 is response (bit 0 timeout status, bit 1 interrupt enable, bit 2 warm-reset enable). A read strobe returns the selected register's current contents on `bus_rdata` one cycle later.
- R3: While run is set, the counter advances by one every `TICK_DIV` (default 2) clocks. A write to count loads the written value and restarts the tick phase, so the counter holds n exactly `TICK_DIV`·n edges after the write or enable edge. The counter never advances by more than one in a cycle.
- R4: When the counter equals the limit while run is set, the expired flag and the timeout status are both set on the following clock edge. This also holds for a limit of zero.
- R5: A timeout pulses `nmi_req` only when interrupt enable is set, and pulses `wrst_req` only when warm-reset enable is set. Both pulse when both are set. Neither pulses when both are clear, and the flags are still set.
- R6: Each timeout gives exactly one request pulse, one cycle wide. The counter then holds at the limit and no further event occurs until count is written, even if the expired flag is cleared and run stays set.
- R7: Writing zero to count before it reaches the limit prevents any timeout.
- R8: While run is clear, the counter holds its value and no timeout occurs.
- R9: Writing 0 to a sticky flag bit clears it. Writing 1 leaves it unchanged and cannot set it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W | Register word address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid the cycle after `bus_rd` |
| nmi_req | output | 1 | One-cycle non-maskable interrupt request |
| wrst_req | output | 1 | One-cycle warm-reset request |

## Verification
The bench checks the exact edge on which the pulse appears for several limits, including zero. A design that compared one tick late, or that ignored the tick phase after enable, would miss that edge. It covers all four combinations of the response enables. Routing the event to the wrong output, or gating the flags with the enables, would show up there. After a timeout it clears the expired flag and leaves the timer running to confirm that nothing fires again. A design that wrapped or re-armed would produce a second pulse. It also checks that writing 1 cannot set a sticky flag, that disabling freezes the count, and that periodic zero writes hold off the event.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
   localparam int unsigned REG_CTRL    = 0;
   localparam int unsigned REG_COUNT   = 1;
   localparam int unsigned REG_LIMIT   = 2;
   localparam int unsigned REG_RESP    = 3;
   localparam int unsigned CTRL_RUN_B  = 0;
   localparam int unsigned CTRL_EXP_B  = 1;
   localparam int unsigned RESP_STAT_B = 0;
   localparam int unsigned RESP_NMI_B  = 1;
   localparam int unsigned RESP_WRST_B = 2;
endpackage

// File: rtl/wdt_tick_div.sv
module wdt_tick_div #(
   parameter int unsigned DIV = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic restart,
   output logic tick
);
   localparam int unsigned PH_W = (DIV > 1) ? $clog2(DIV) : 1;

   generate
      if (DIV < 1) begin : g_bad_div
         $error("wdt_tick_div: DIV must be at least 1");
      end
      if (DIV == 1) begin : g_every
         assign tick = run;
      end else begin : g_divided
         logic [PH_W-1:0] phase_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               phase_q <= '0;
            else if (!run || restart)
               phase_q <= '0;
            else if (phase_q == PH_W'(DIV - 1))
               phase_q <= '0;
            else
               phase_q <= phase_q + 1'b1;
         end
         assign tick = run && (phase_q == PH_W'(DIV - 1));
      end
   endgenerate
endmodule

// File: rtl/wdt_count_unit.sv
module wdt_count_unit #(
   parameter int unsigned W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         run,
   input  logic         tick,
   input  logic         load,
   input  logic [W-1:0] load_val,
   input  logic [W-1:0] limit,
   output logic [W-1:0] count,
   output logic         fire
);
   logic parked_q;
   logic at_limit;

   assign at_limit = (count == limit);
   assign fire     = run && at_limit && !parked_q && !load;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count    <= '0;
         parked_q <= 1'b0;
      end else begin
         if (load)
            count <= load_val;
         else if (run && tick && !at_limit && !parked_q)
            count <= count + 1'b1;

         if (load)
            parked_q <= 1'b0;
         else if (fire)
            parked_q <= 1'b1;
      end
   end
endmodule

// File: rtl/wdt_regs.sv
module wdt_regs
   import wdt_pkg::*;
#(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned ADDR_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic [DATA_W-1:0] count,
   input  logic              fire,
   output logic              run_en,
   output logic              exp_flag,
   output logic              stat_flag,
   output logic              nmi_en,
   output logic              wrst_en,
   output logic [DATA_W-1:0] limit,
   output logic              cnt_wr,
   output logic              lim_wr,
   output logic              nmi_req,
   output logic              wrst_req
);
   logic ctrl_wr, resp_wr;

   assign ctrl_wr = bus_wr && (bus_addr == ADDR_W'(REG_CTRL));
   assign cnt_wr  = bus_wr && (bus_addr == ADDR_W'(REG_COUNT));
   assign lim_wr  = bus_wr && (bus_addr == ADDR_W'(REG_LIMIT));
   assign resp_wr = bus_wr && (bus_addr == ADDR_W'(REG_RESP));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_en    <= 1'b0;
         exp_flag  <= 1'b0;
         stat_flag <= 1'b0;
         nmi_en    <= 1'b0;
         wrst_en   <= 1'b0;
         limit     <= '0;
         nmi_req   <= 1'b0;
         wrst_req  <= 1'b0;
         bus_rdata <= '0;
      end else begin
         if (ctrl_wr) run_en <= bus_wdata[CTRL_RUN_B];
         exp_flag  <= fire || (exp_flag && !(ctrl_wr && !bus_wdata[CTRL_EXP_B]));
         stat_flag <= fire || (stat_flag && !(resp_wr && !bus_wdata[RESP_STAT_B]));
         if (resp_wr) begin
            nmi_en  <= bus_wdata[RESP_NMI_B];
            wrst_en <= bus_wdata[RESP_WRST_B];
         end
         if (lim_wr) limit <= bus_wdata;
         nmi_req  <= fire && nmi_en;
         wrst_req <= fire && wrst_en;
         if (bus_rd) begin
            bus_rdata <= '0;
            case (bus_addr)
               ADDR_W'(REG_CTRL): begin
                  bus_rdata[CTRL_RUN_B] <= run_en;
                  bus_rdata[CTRL_EXP_B] <= exp_flag;
               end
               ADDR_W'(REG_COUNT): bus_rdata <= count;
               ADDR_W'(REG_LIMIT): bus_rdata <= limit;
               ADDR_W'(REG_RESP): begin
                  bus_rdata[RESP_STAT_B] <= stat_flag;
                  bus_rdata[RESP_NMI_B]  <= nmi_en;
                  bus_rdata[RESP_WRST_B] <= wrst_en;
               end
               default: bus_rdata <= '0;
            endcase
         end
      end
   end
endmodule

// File: rtl/wdog_timer.sv
module wdog_timer #(
   parameter int unsigned DATA_W   = 32,
   parameter int unsigned ADDR_W   = 2,
   parameter int unsigned TICK_DIV = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              nmi_req,
   output logic              wrst_req
);
   generate
      if (DATA_W < 3) begin : g_bad_data
         $error("wdog_timer: DATA_W must hold the response field");
      end
      if (ADDR_W < 2) begin : g_bad_addr
         $error("wdog_timer: ADDR_W must cover four registers");
      end
   endgenerate

   logic              run_en, exp_flag, stat_flag, nmi_en, wrst_en;
   logic              cnt_wr, lim_wr, tick, fire;
   logic [DATA_W-1:0] limit, count_q;

   wdt_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
      .clk(clk), .rst_n(rst_n),
      .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .count(count_q), .fire(fire),
      .run_en(run_en), .exp_flag(exp_flag), .stat_flag(stat_flag),
      .nmi_en(nmi_en), .wrst_en(wrst_en), .limit(limit),
      .cnt_wr(cnt_wr), .lim_wr(lim_wr),
      .nmi_req(nmi_req), .wrst_req(wrst_req)
   );

   wdt_tick_div #(.DIV(TICK_DIV)) u_tick (
      .clk(clk), .rst_n(rst_n), .run(run_en), .restart(cnt_wr), .tick(tick)
   );

   wdt_count_unit #(.W(DATA_W)) u_count (
      .clk(clk), .rst_n(rst_n), .run(run_en), .tick(tick),
      .load(cnt_wr), .load_val(bus_wdata), .limit(limit),
      .count(count_q), .fire(fire)
   );
endmodule

// File: rtl/wdog_timer_chk.sv
module wdog_timer_chk #(
   parameter int unsigned W = 32
) (
   input logic         clk,
   input logic         rst_n,
   input logic         run_en,
   input logic         cnt_wr,
   input logic         lim_wr,
   input logic [W-1:0] count_q,
   input logic [W-1:0] limit,
   input logic         exp_flag,
   input logic         stat_flag,
   input logic         nmi_en,
   input logic         wrst_en,
   input logic         nmi_req,
   input logic         wrst_req
);
   AST_NMI_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      nmi_req |=> !nmi_req); // R6
   AST_WRST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      wrst_req |=> !wrst_req); // R6
   AST_NMI_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(nmi_req) |-> $past(nmi_en)); // R5
   AST_WRST_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wrst_req) |-> $past(wrst_en)); // R5
   AST_REQ_SETS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
      (nmi_req || wrst_req) |-> (exp_flag && stat_flag)); // R4
   AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      (!run_en && !cnt_wr) |=> $stable(count_q)); // R8
   AST_PARK_AT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
      (count_q == limit && !cnt_wr && !lim_wr) |=> $stable(count_q)); // R6
   AST_STEP_BY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      !cnt_wr |=> (count_q == $past(count_q) || count_q == $past(count_q) + 1'b1)); // R3
endmodule

bind wdog_timer wdog_timer_chk #(.W(DATA_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .run_en(run_en), .cnt_wr(cnt_wr), .lim_wr(lim_wr),
   .count_q(count_q), .limit(limit), .exp_flag(exp_flag), .stat_flag(stat_flag),
   .nmi_en(nmi_en), .wrst_en(wrst_en), .nmi_req(nmi_req), .wrst_req(wrst_req)
);

// File: tb/wdog_timer_tb.sv
module wdog_timer_tb;
   localparam int NV = 6;
   // {limit[7:0], nmi_en, wrst_en}
   localparam logic [9:0] VEC [NV] = '{
      {8'd3, 1'b1, 1'b0}, {8'd0, 1'b0, 1'b1}, {8'd7, 1'b1, 1'b1},
      {8'd1, 1'b0, 1'b0}, {8'd12, 1'b0, 1'b1}, {8'd5, 1'b1, 1'b1}};

   logic        clk = 1'b0, rst_n = 1'b0;
   logic [1:0]  bus_addr = '0;
   logic        bus_wr = 1'b0, bus_rd = 1'b0;
   logic [31:0] bus_wdata = '0, bus_rdata;
   logic        nmi_req, wrst_req;
   int          checks = 0, failures = 0;
   int          nmi_cnt = 0, wrst_cnt = 0;
   logic [31:0] rv;

   always #2 clk = ~clk;

   wdog_timer u_dut (.clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .nmi_req(nmi_req), .wrst_req(wrst_req));

   always @(negedge clk) begin
      if (nmi_req) nmi_cnt++;
      if (wrst_req) wrst_cnt++;
   end

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_rd = 1'b1;
      @(negedge clk);
      bus_rd = 1'b0;
      d = bus_rdata;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      idle(3);
      rst_n = 1'b1;
      idle(2);
      // R1: reset state
      check("R1 nmi_req", {31'd0, nmi_req}, 32'd0);
      check("R1 wrst_req", {31'd0, wrst_req}, 32'd0);
      for (int a = 0; a < 4; a++) begin
         rd(a[1:0], rv);
         check("R1 register zero", rv, 32'd0);
      end

      // R2: readback of limit
      wr(2'd2, 32'hA5C3_0F1E);
      rd(2'd2, rv);
      check("R2 limit readback", rv, 32'hA5C3_0F1E);

      // Vector walk: R3 R4 R5 R6
      for (int v = 0; v < NV; v++) begin
         int lim, ne, we, bad_n, bad_w;
         lim = int'(VEC[v][9:2]); ne = int'(VEC[v][1]); we = int'(VEC[v][0]);
         wr(2'd0, 32'd0);
         wr(2'd3, 32'((we << 2) | (ne << 1)));
         wr(2'd2, 32'(lim));
         wr(2'd1, 32'd0);
         nmi_cnt = 0; wrst_cnt = 0;
         wr(2'd0, 32'd1);
         bad_n = 0; bad_w = 0;
         for (int k = 1; k <= 2 * lim + 6; k++) begin
            if (nmi_req !== ((k == 2 * lim + 2) && ne == 1)) bad_n++;
            if (wrst_req !== ((k == 2 * lim + 2) && we == 1)) bad_w++;
            @(negedge clk);
         end
         check("R3 R4 nmi pulse timing", 32'(bad_n), 32'd0);
         check("R3 R5 wrst pulse timing", 32'(bad_w), 32'd0);
         check("R6 nmi pulse count", 32'(nmi_cnt), 32'(ne));
         check("R5 wrst pulse count", 32'(wrst_cnt), 32'(we));
         rd(2'd0, rv);
         check("R4 control expired+run", rv, 32'd3);
         rd(2'd3, rv);
         check("R4 response status", rv, 32'((we << 2) | (ne << 1) | 1));
         rd(2'd1, rv);
         check("R6 count parked at limit", rv, 32'(lim));
      end

      // R9 / R6: clear flags, keep running, no second event (limit 5, both enabled)
      wr(2'd0, 32'h0000_0003);
      rd(2'd0, rv);
      check("R9 write 1 keeps expired", rv, 32'd3);
      wr(2'd0, 32'd1);
      rd(2'd0, rv);
      check("R9 write 0 clears expired", rv, 32'd1);
      wr(2'd3, 32'h0000_0006);
      rd(2'd3, rv);
      check("R9 write 0 clears status", rv, 32'd6);
      wr(2'd3, 32'h0000_0007);
      rd(2'd3, rv);
      check("R9 write 1 cannot set status", rv, 32'd6);
      nmi_cnt = 0; wrst_cnt = 0;
      idle(30);
      check("R6 no second nmi", 32'(nmi_cnt), 32'd0);
      rd(2'd1, rv);
      check("R6 count still parked", rv, 32'd5);
      wr(2'd1, 32'd0);
      idle(20);
      check("R6 count write re-arms", 32'(nmi_cnt), 32'd1);

      // R7: keep-alive
      wr(2'd0, 32'd0);
      wr(2'd3, 32'h0000_0006);
      wr(2'd2, 32'd20);
      wr(2'd1, 32'd0);
      nmi_cnt = 0; wrst_cnt = 0;
      wr(2'd0, 32'd1);
      for (int i = 0; i < 8; i++) begin
         idle(20);
         wr(2'd1, 32'd0);
      end
      check("R7 keep-alive nmi", 32'(nmi_cnt), 32'd0);
      check("R7 keep-alive wrst", 32'(wrst_cnt), 32'd0);
      rd(2'd0, rv);
      check("R7 no expired flag", rv, 32'd1);

      // R8: disable freezes count
      idle(10);
      wr(2'd0, 32'd0);
      rd(2'd1, rv);
      idle(40);
      begin
         logic [31:0] rv2;
         rd(2'd1, rv2);
         check("R8 count frozen", rv2, rv);
      end
      check("R8 no event while off", 32'(nmi_cnt + wrst_cnt), 32'd0);

      // R3: count write loads value
      wr(2'd1, 32'd9);
      rd(2'd1, rv);
      check("R3 count load", rv, 32'd9);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule